// File: doc/BRIEF.md
# MDIO Station Management Master

This block is the station-management side of the two-wire management bus used to configure and poll Ethernet PHY devices. A host presents one command (an operation code, a 5-bit PHY address, a 5-bit register or device field, a 16-bit register address for extended accesses and 16 bits of write data). The block serialises the command onto the bus and returns a one-cycle done pulse. For reads it also returns the 16 data bits and a no-response flag.

The management clock MDC is derived from the system clock by a parameterised divider. It runs only while a transaction is in flight and rests low otherwise. The data line is open-drain. The block never drives it high: it only asserts an output-enable that pulls the line low for a 0 bit and releases it for every 1 bit, for the preamble, and for the turnaround and data bits of a read. One engine serves both frame styles. A short-form access is one frame. An extended access is an address frame that carries the full 16-bit register address, followed by a frame that moves the data.

Top module: `mdio_master`

## Requirements
- R1: After reset `busy`, `done`, `mdc` and `mdio_oe` are all 0.
- R2: `cmd_op` 00 is a short-form write. Each frame starts with 32 released bits (read as 1), followed by the 32 frame bits MSB first: start 01, opcode 01, PHY address, register address, turnaround 10, then the 16 write-data bits.
- R3: `cmd_op` 01 is a short-form read. The frame bits are start 01, opcode 10, PHY address and register address. The line is then released for the two turnaround bits and the 16 data bits. The data seen on the line at the MDC rising edges, MSB first, appears on `rd_data` when `done` pulses.
- R4: On a read, `rd_err` is 1 with `done` when the line is not 0 in the second turnaround bit, and 0 when the PHY pulls it low there. After a write `rd_err` is 0.
- R5: `cmd_op` 10 is an extended write, sent as two frames. The first frame is start 00, opcode 00, PHY address, device field, turnaround 10 and the 16-bit `cmd_addr`. The second frame is start 00, opcode 01, the same addresses, turnaround 10 and the write data.
- R6: `cmd_op` 11 is an extended read. It sends the same address frame as R5, then a frame with start 00 and opcode 11 that is released from the turnaround on, as in R3. Its data and turnaround result are returned as in R3 and R4.
- R7: MDC is high for `MDC_HALF` system cycles in each period and low while the block is idle. `mdio_oe` changes only in the cycle in which MDC has just risen.
- R8: `mdio_oe` is asserted only for frame bits whose value is 0. A data bit of 1 leaves the line released.
- R9: `busy` rises in the cycle after a command is accepted and stays high until `done`. A `cmd_valid` seen while `busy` is high is ignored and produces no frame.
- R10: After the last frame the line stays released for one further MDC rising edge. `done` then pulses for exactly one cycle, and `busy` is low from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_op | input | 2 | Bit 0 set = read, bit 1 set = extended (two-frame) access |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address (short form) or device field (extended) |
| cmd_addr | input | 16 | Register address for the extended address frame |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Data captured by the last read |
| rd_err | output | 1 | No-response flag of the last transaction |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Pull the data line low when 1 |
| mdio_i | input | 1 | Sampled state of the data line |

## Verification
A bench model of a PHY answers reads at the turnaround. In the no-response case it stays silent, so a master that ignored the second turnaround bit would report good data with no error. A master that drove the line during the turnaround would corrupt the captured read word. An all-ones write shows whether 1 bits are released or actively driven. An extended access must produce exactly two frames with the right start and opcode pairs, so a sequencer that skipped the address frame or reused the write opcode fails the frame compare. A command injected mid-transaction must leave no extra frame on the bus. The gap count before `done` catches a master that reports completion while MDC is still high or without the idle bit.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam logic [1:0] ST_SHORT   = 2'b01;
    localparam logic [1:0] ST_EXT     = 2'b00;
    localparam logic [1:0] OPS_WRITE  = 2'b01;
    localparam logic [1:0] OPS_READ   = 2'b10;
    localparam logic [1:0] OPX_ADDR   = 2'b00;
    localparam logic [1:0] OPX_WRITE  = 2'b01;
    localparam logic [1:0] OPX_READ   = 2'b11;
    localparam logic [1:0] TA_DRIVEN  = 2'b10;
    localparam int unsigned FRAME_BITS = 32;

    typedef struct packed {
        logic [1:0]  st;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regdev;
        logic [15:0] data;
    } mdio_frame_t;

    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_ADDR = 2'd1,
        T_DATA = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        E_IDLE  = 2'd0,
        E_SHIFT = 2'd1,
        E_TAIL  = 2'd2
    } eng_state_e;

    function automatic mdio_frame_t make_frame(
        input logic [1:0] st, input logic [1:0] op,
        input logic [4:0] phy, input logic [4:0] regdev,
        input logic [15:0] data);
        mdio_frame_t f;
        f.st = st;
        f.op = op;
        f.phy = phy;
        f.regdev = regdev;
        f.data = data;
        return f;
    endfunction

    function automatic logic [FRAME_BITS-1:0] frame_word(input mdio_frame_t f);
        return {f.st, f.op, f.phy, f.regdev, TA_DRIVEN, f.data};
    endfunction

endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
    parameter int unsigned HALF_CYC = 52
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int unsigned CW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = en && (cnt == LAST);
    assign rise = tick && !mdc;
    assign fall = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R7
    rise_hi_chk: assert property (@(posedge clk) disable iff (rst) rise |=> mdc);
    // R7
    fall_lo_chk: assert property (@(posedge clk) disable iff (rst) fall |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int unsigned PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  mdio_frame_t frame_in,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        active,
    output logic        mdio_oe,
    output logic        frame_done,
    output logic [15:0] rd_data,
    output logic        ta_err
);
    localparam int unsigned TOTAL = PRE_BITS + FRAME_BITS;
    localparam int unsigned IW    = $clog2(TOTAL + 1);
    localparam logic [IW-1:0] IDX_FRM = IW'(PRE_BITS);
    localparam logic [IW-1:0] IDX_REL = IW'(PRE_BITS + 14);
    localparam logic [IW-1:0] IDX_TA2 = IW'(PRE_BITS + 15);
    localparam logic [IW-1:0] IDX_DAT = IW'(PRE_BITS + 16);
    localparam logic [IW-1:0] IDX_GAP = IW'(TOTAL);

    eng_state_e            state;
    logic [IW-1:0]         bit_idx;
    logic [FRAME_BITS-1:0] word_q;
    logic                  rd_q;
    logic [IW-1:0]         rel_idx;
    logic [4:0]            fpos;
    logic                  in_frame;

    assign rel_idx  = bit_idx - IDX_FRM;
    assign fpos     = rel_idx[4:0];
    assign in_frame = (bit_idx >= IDX_FRM) && (bit_idx < IDX_GAP);
    assign active   = (state != E_IDLE);
    assign mdio_oe  = (state == E_SHIFT) && in_frame
                   && !(rd_q && (bit_idx >= IDX_REL))
                   && !word_q[5'd31 - fpos];

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= E_IDLE;
            bit_idx    <= '0;
            word_q     <= '0;
            rd_q       <= 1'b0;
            frame_done <= 1'b0;
            rd_data    <= '0;
            ta_err     <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            unique case (state)
                E_IDLE: begin
                    if (start) begin
                        word_q  <= frame_word(frame_in);
                        rd_q    <= frame_in.op[1];
                        bit_idx <= '0;
                        ta_err  <= 1'b0;
                        state   <= E_SHIFT;
                    end
                end
                E_SHIFT: begin
                    if (rise) begin
                        if (rd_q && bit_idx == IDX_TA2) begin
                            ta_err <= mdio_i;
                        end
                        if (rd_q && bit_idx >= IDX_DAT && bit_idx < IDX_GAP) begin
                            rd_data <= {rd_data[14:0], mdio_i};
                        end
                        if (bit_idx == IDX_GAP) begin
                            state <= E_TAIL;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                E_TAIL: begin
                    if (fall) begin
                        state      <= E_IDLE;
                        frame_done <= 1'b1;
                    end
                end
                default: state <= E_IDLE;
            endcase
        end
    end

    // R7
    oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_oe) |-> $past(rise));
    // R8
    pre_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == E_SHIFT && bit_idx < IDX_FRM) |-> !mdio_oe);
    // R10
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mdio_oe);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int unsigned MDC_HALF = 52,
    parameter int unsigned PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [4:0]  cmd_phy,
    input  logic [4:0]  cmd_reg,
    input  logic [15:0] cmd_addr,
    input  logic [15:0] cmd_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        rd_err,
    output logic        mdc,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    seq_state_e  st;
    logic [1:0]  op_q;
    logic [4:0]  phy_q;
    logic [4:0]  reg_q;
    logic [15:0] wd_q;
    logic        eng_start;
    mdio_frame_t eng_frame;
    logic        eng_active;
    logic        eng_done;
    logic [15:0] eng_rd;
    logic        eng_err;
    logic        mdc_rise;
    logic        mdc_fall;

    mdc_divider #(.HALF_CYC(MDC_HALF)) u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (eng_active),
        .mdc  (mdc),
        .rise (mdc_rise),
        .fall (mdc_fall)
    );

    mdio_frame_engine #(.PRE_BITS(PRE_BITS)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .start      (eng_start),
        .frame_in   (eng_frame),
        .rise       (mdc_rise),
        .fall       (mdc_fall),
        .mdio_i     (mdio_i),
        .active     (eng_active),
        .mdio_oe    (mdio_oe),
        .frame_done (eng_done),
        .rd_data    (eng_rd),
        .ta_err     (eng_err)
    );

    assign busy = (st != T_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= T_IDLE;
            op_q      <= '0;
            phy_q     <= '0;
            reg_q     <= '0;
            wd_q      <= '0;
            eng_start <= 1'b0;
            eng_frame <= '0;
            done      <= 1'b0;
            rd_data   <= '0;
            rd_err    <= 1'b0;
        end else begin
            eng_start <= 1'b0;
            done      <= 1'b0;
            unique case (st)
                T_IDLE: begin
                    if (cmd_valid) begin
                        op_q      <= cmd_op;
                        phy_q     <= cmd_phy;
                        reg_q     <= cmd_reg;
                        wd_q      <= cmd_wdata;
                        eng_start <= 1'b1;
                        if (cmd_op[1]) begin
                            eng_frame <= make_frame(ST_EXT, OPX_ADDR, cmd_phy, cmd_reg, cmd_addr);
                            st        <= T_ADDR;
                        end else begin
                            eng_frame <= make_frame(ST_SHORT, cmd_op[0] ? OPS_READ : OPS_WRITE,
                                                    cmd_phy, cmd_reg, cmd_wdata);
                            st        <= T_DATA;
                        end
                    end
                end
                T_ADDR: begin
                    if (eng_done) begin
                        eng_start <= 1'b1;
                        eng_frame <= make_frame(ST_EXT, op_q[0] ? OPX_READ : OPX_WRITE,
                                                phy_q, reg_q, wd_q);
                        st        <= T_DATA;
                    end
                end
                T_DATA: begin
                    if (eng_done) begin
                        done   <= 1'b1;
                        rd_err <= op_q[0] & eng_err;
                        if (op_q[0]) begin
                            rd_data <= eng_rd;
                        end
                        st <= T_IDLE;
                    end
                end
                default: st <= T_IDLE;
            endcase
        end
    end

    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7
    mdc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !eng_active));

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
    localparam int unsigned HALF = 3;

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [4:0]  cmd_phy;
    logic [4:0]  cmd_reg;
    logic [15:0] cmd_addr;
    logic [15:0] cmd_wdata;
    logic        busy, done, rd_err, mdc, mdio_oe;
    logic [15:0] rd_data;
    logic        phy_low = 1'b0;
    logic        mdio_line;

    assign mdio_line = !(mdio_oe || phy_low);

    always #2 clk = ~clk;

    mdio_master #(.MDC_HALF(HALF), .PRE_BITS(32)) i_mdio_master (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .rd_err(rd_err), .mdc(mdc), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fw(input logic [1:0] s, input logic [1:0] o,
        input logic [4:0] p, input logic [4:0] r, input logic [1:0] ta, input logic [15:0] d);
        return {s, o, p, r, ta, d};
    endfunction

    // bus monitor + PHY model, sampled away from the active edge
    logic        prev_mdc = 0;
    logic        prev_line = 1;
    logic        prev_oe = 0;
    bit          in_frame = 0;
    int          ones = 0;
    int          fpos = 0;
    logic [31:0] cap = '0;
    bit          rdflag = 0;
    int          rises_since = 0;
    int          hi_cnt = 0;
    int          mdc_bad = 0;
    int          oe_bad = 0;
    int          rel_bad = 0;
    bit          phy_resp = 0;
    logic [15:0] phy_val = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mdio_oe != prev_oe && !(mdc && !prev_mdc)) oe_bad++;
            if (mdc) hi_cnt++;
            if (in_frame && rdflag && fpos >= 14 && mdio_oe) rel_bad++;
            if (mdc && !prev_mdc) begin
                if (!in_frame) begin
                    rises_since++;
                    if (prev_line) ones++;
                    else if (ones >= 32) begin
                        in_frame = 1; cap = '0; fpos = 1; rdflag = 0;
                    end else begin
                        chk(0, "R2 preamble", 32'(ones), 32);
                        ones = 0;
                    end
                end else begin
                    cap = {cap[30:0], prev_line};
                    fpos++;
                    if (fpos == 4) rdflag = cap[1];
                    if (fpos == 32) begin
                        if (exp_q.size() == 0) chk(0, "R9 unexpected frame", cap, 0);
                        else begin
                            logic [31:0] e;
                            string t;
                            e = exp_q.pop_front();
                            t = tag_q.pop_front();
                            chk(cap == e, t, cap, e);
                        end
                        in_frame = 0; ones = 0; rises_since = 0; fpos = 0; rdflag = 0;
                    end
                end
            end
            if (!mdc && prev_mdc) begin
                if (hi_cnt != HALF) mdc_bad++;
                hi_cnt = 0;
                phy_low = 0;
                if (in_frame && rdflag && phy_resp) begin
                    if (fpos == 15) phy_low = 1;
                    else if (fpos >= 16 && fpos <= 31) phy_low = !phy_val[31 - fpos];
                end
            end
        end
        prev_mdc  = mdc;
        prev_oe   = mdio_oe;
        prev_line = !(mdio_oe || phy_low);
    end

    task automatic run_txn(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r,
        input logic [15:0] a16, input logic [15:0] wd, input bit resp,
        input logic [15:0] rv, input bit inject, input string tag);
        logic [15:0] got;
        logic [1:0]  ta_line;
        got = resp ? rv : 16'hFFFF;
        ta_line = resp ? 2'b10 : 2'b11;
        phy_resp = resp;
        phy_val = rv;
        case (op)
            2'b00: begin exp_q.push_back(fw(2'b01, 2'b01, p, r, 2'b10, wd)); tag_q.push_back({tag, " frame"}); end
            2'b01: begin exp_q.push_back(fw(2'b01, 2'b10, p, r, ta_line, got)); tag_q.push_back({tag, " frame"}); end
            2'b10: begin
                exp_q.push_back(fw(2'b00, 2'b00, p, r, 2'b10, a16)); tag_q.push_back({tag, " addr frame"});
                exp_q.push_back(fw(2'b00, 2'b01, p, r, 2'b10, wd));  tag_q.push_back({tag, " data frame"});
            end
            default: begin
                exp_q.push_back(fw(2'b00, 2'b00, p, r, 2'b10, a16)); tag_q.push_back({tag, " addr frame"});
                exp_q.push_back(fw(2'b00, 2'b11, p, r, ta_line, got)); tag_q.push_back({tag, " read frame"});
            end
        endcase
        cmd_op = op; cmd_phy = p; cmd_reg = r; cmd_addr = a16; cmd_wdata = wd;
        cmd_valid = 1;
        @(negedge clk);
        cmd_valid = 0;
        chk(busy === 1'b1, "R9 busy after accept", 32'(busy), 1);
        if (inject) begin
            repeat (60) @(negedge clk);
            cmd_op = 2'b00; cmd_phy = ~p; cmd_reg = ~r; cmd_wdata = ~wd;
            cmd_valid = 1;
            @(negedge clk);
            cmd_valid = 0;
            chk(busy === 1'b1, "R9 still busy", 32'(busy), 1);
        end
        while (done !== 1'b1) @(negedge clk);
        chk(rises_since == 1, "R10 idle bit before done", 32'(rises_since), 1);
        chk(exp_q.size() == 0, "R5 R6 frame count", 32'(exp_q.size()), 0);
        if (op[0]) begin
            chk(rd_data == got, "R3 R6 read data", 32'(rd_data), 32'(got));
            chk(rd_err == !resp, "R4 no-response flag", 32'(rd_err), 32'(!resp));
        end else begin
            chk(rd_err == 1'b0, "R4 write clears flag", 32'(rd_err), 0);
        end
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10 single pulse", {30'b0, done, busy}, 0);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; cmd_valid = 0; cmd_op = 0; cmd_phy = 0; cmd_reg = 0; cmd_addr = 0; cmd_wdata = 0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1
        chk({busy, done, mdc, mdio_oe} == 4'b0, "R1 reset state", {28'b0, busy, done, mdc, mdio_oe}, 0);

        run_txn(2'b00, 5'd5,  5'd0,  16'h0000, 16'hA5C3, 0, 16'h0000, 0, "R2 short write");
        run_txn(2'b00, 5'd31, 5'd31, 16'h0000, 16'hFFFF, 0, 16'h0000, 0, "R8 all-ones write");
        run_txn(2'b01, 5'd1,  5'd2,  16'h0000, 16'h0000, 1, 16'h2000, 0, "R3 short read");
        run_txn(2'b01, 5'd9,  5'd3,  16'h0000, 16'h0000, 0, 16'h0000, 0, "R4 silent read");
        run_txn(2'b10, 5'd3,  5'd1,  16'h1234, 16'hBEEF, 0, 16'h0000, 0, "R5 ext write");
        run_txn(2'b11, 5'd7,  5'd7,  16'h0001, 16'h0000, 1, 16'h8001, 0, "R6 ext read");
        run_txn(2'b11, 5'd0,  5'd30, 16'hFFFE, 16'h0000, 0, 16'h0000, 0, "R6 ext silent read");
        run_txn(2'b00, 5'd12, 5'd4,  16'h0000, 16'h0001, 0, 16'h0000, 1, "R9 ignored command");

        // R7
        chk(mdc_bad == 0, "R7 MDC high time", 32'(mdc_bad), 0);
        chk(oe_bad == 0, "R7 line changes after rising edge", 32'(oe_bad), 0);
        // R3
        chk(rel_bad == 0, "R3 released during read turnaround and data", 32'(rel_bad), 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle at end", {30'b0, mdc, mdio_oe}, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule